// File: doc/BRIEF.md
# Aperiodic Polarity-Marker DC Balancer

This block keeps the running balance of ones and zeros on a serial line inside a fixed window, at a low bit overhead. The encoder forwards payload bits untouched while the running balance is small. Once the magnitude of the balance reaches a threshold `T`, it gathers the next `S` payload bits as one group. If the group is unbalanced and would push the line further in the direction it already leans, the encoder sends the group inverted. An unbalanced group is always followed by one marker bit that records whether it was inverted. A balanced group goes out unchanged and gets no marker, so markers appear only where they are needed and not on a fixed frame grid.

The decoder keeps the same running balance on the received line bits. From it the decoder knows when a group starts and whether a marker follows. It removes the marker, undoes any inversion and restores the original bit sequence. Both directions are bit-serial valid/ready streams. They are independent inside the top module, so one instance can serve as the transmit end and another as the receive end of a link, or a single instance can be looped back. `T` and `S` are elaboration parameters. `S` must be even and `T` must exceed `S/2`.

Top module: `pbal_codec`

## Requirements
- R1: Each line bit counts +1 for a 1 and -1 for a 0, and the balance is 0 after reset. The running sum of line bits sent stays within ±(T + S/2) at all times.
- R2: No run of identical line bits is longer than 2·(T + S/2).
- R3: While the magnitude of the line balance is below T, a payload bit appears on the line in the same cycle it is accepted, unchanged.
- R4: When the balance magnitude has reached T, the next S payload bits form a group. A group whose own sum is zero is sent unchanged and is not followed by a marker bit.
- R5: A group whose sum is nonzero and has the same sign as the line balance is sent with every bit inverted and is followed by a marker bit of 1. A group whose nonzero sum has the opposite sign is sent unchanged and is followed by a marker bit of 0. The marker counts in the balance.
- R6: The decoder output reproduces the encoder input bit for bit, in order, with no loss or repetition, under any stalling of source, line or sink.
- R7: While a group bit or a marker bit is on the line, the encoder holds `src_ready` low.
- R8: After reset with no input offered, `line_tx_valid` and `snk_valid` are low and `src_ready` follows the line's ready.
- R9: While a group is being gathered, the encoder accepts payload bits with `src_ready` high and keeps `line_tx_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Payload bit offered to the encoder |
| src_ready | output | 1 | Encoder accepts the payload bit |
| src_bit | input | 1 | Payload bit value |
| line_tx_valid | output | 1 | Encoded line bit available |
| line_tx_ready | input | 1 | Line accepts the encoded bit |
| line_tx_bit | output | 1 | Encoded line bit value |
| line_rx_valid | input | 1 | Received line bit offered to the decoder |
| line_rx_ready | output | 1 | Decoder accepts the line bit |
| line_rx_bit | input | 1 | Received line bit value |
| snk_valid | output | 1 | Restored payload bit available |
| snk_ready | input | 1 | Sink accepts the restored bit |
| snk_bit | output | 1 | Restored payload bit value |

## Verification
Every 10-bit payload word is sent back to back as one long stream at full rate. This drives the balance through both signs and produces balanced groups, kept groups and inverted groups in every order, so a wrong inversion choice or a missing marker shows up against the arithmetic line model. A second pass sends every 8-bit word while source, line and sink stall in a pseudo-random pattern. That pass separates flow-control faults (lost, doubled or reordered bits, ready asserted while a group is going out) from coding faults. Each observed line bit is also checked for the balance bound and the run-length bound, and the decoded stream is compared with the payload.

// File: rtl/pbal_pkg.sv
package pbal_pkg;

    typedef enum logic [1:0] {
        PH_OPEN,
        PH_FILL,
        PH_SEND,
        PH_MARK
    } pbal_phase_e;

    typedef struct packed {
        logic invert;
        logic marked;
    } grp_ctl_t;

    function automatic logic past_limit(int level, int thresh);
        return (level >= thresh) || (level <= -thresh);
    endfunction

    function automatic logic wants_invert(logic g_nz, logic g_pos, int level);
        return g_nz && (g_pos == (level > 0));
    endfunction

endpackage

// File: rtl/pbal_crd.sv
module pbal_crd #(
    parameter int T = 2,
    parameter int S = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic bit_in,
    output int   level
);
    localparam int CW = $clog2(T + S / 2 + 2) + 2;
    localparam logic signed [CW-1:0] UP = 1;
    localparam logic signed [CW-1:0] DN = -1;

    logic signed [CW-1:0] crd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crd_q <= '0;
        end else if (step) begin
            crd_q <= crd_q + (bit_in ? UP : DN);
        end
    end

    assign level = int'(crd_q);
endmodule

// File: rtl/pbal_group.sv
module pbal_group #(
    parameter int S = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  logic bit_in,
    output logic head,
    output logic last,
    output logic g_nz,
    output logic g_pos
);
    localparam int CNTW = $clog2(S);
    localparam int GW   = $clog2(S + 1) + 1;
    localparam logic signed [GW-1:0] UP = 1;
    localparam logic signed [GW-1:0] DN = -1;

    logic [S-1:0]           store_q;
    logic [CNTW-1:0]        idx_q;
    logic signed [GW-1:0]   gsum_q;
    logic signed [GW-1:0]   gsum_nx;

    assign last = (idx_q == CNTW'(S - 1));
    assign head = store_q[idx_q];

    always_comb begin
        if (idx_q == '0) begin
            gsum_nx = bit_in ? UP : DN;
        end else begin
            gsum_nx = gsum_q + (bit_in ? UP : DN);
        end
        g_nz  = (gsum_nx != '0);
        g_pos = g_nz && !gsum_nx[GW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
            idx_q   <= '0;
            gsum_q  <= '0;
        end else if (push) begin
            store_q[idx_q] <= bit_in;
            gsum_q         <= gsum_nx;
            idx_q          <= last ? '0 : idx_q + CNTW'(1);
        end else if (pop) begin
            idx_q <= last ? '0 : idx_q + CNTW'(1);
        end
    end
endmodule

// File: rtl/pbal_enc.sv
module pbal_enc
    import pbal_pkg::*;
#(
    parameter int T = 2,
    parameter int S = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit
);
    pbal_phase_e ph_q;
    grp_ctl_t    ctl_q;
    int          level;
    logic        step, step_bit, push, pop;
    logic        head, last, g_nz, g_pos, at_lim;

    pbal_crd #(.T(T), .S(S)) u_crd (
        .clk(clk), .rst(rst), .step(step), .bit_in(step_bit), .level(level)
    );

    pbal_group #(.S(S)) u_grp (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .bit_in(in_bit),
        .head(head), .last(last), .g_nz(g_nz), .g_pos(g_pos)
    );

    assign at_lim = past_limit(level, T);

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_bit   = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        step      = 1'b0;
        step_bit  = 1'b0;
        case (ph_q)
            PH_OPEN: begin
                if (!at_lim) begin
                    in_ready  = out_ready;
                    out_valid = in_valid;
                    out_bit   = in_bit;
                    step      = in_valid && out_ready;
                    step_bit  = in_bit;
                end else begin
                    in_ready = 1'b1;
                    push     = in_valid;
                end
            end
            PH_FILL: begin
                in_ready = 1'b1;
                push     = in_valid;
            end
            PH_SEND: begin
                out_valid = 1'b1;
                out_bit   = head ^ ctl_q.invert;
                pop       = out_ready;
                step      = out_ready;
                step_bit  = out_bit;
            end
            default: begin
                out_valid = 1'b1;
                out_bit   = ctl_q.invert;
                step      = out_ready;
                step_bit  = out_bit;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_OPEN;
            ctl_q <= '0;
        end else begin
            case (ph_q)
                PH_OPEN, PH_FILL: begin
                    if (push) begin
                        if (last) begin
                            ph_q         <= PH_SEND;
                            ctl_q.invert <= wants_invert(g_nz, g_pos, level);
                            ctl_q.marked <= g_nz;
                        end else begin
                            ph_q <= PH_FILL;
                        end
                    end
                end
                PH_SEND: begin
                    if (out_ready && last) begin
                        ph_q <= ctl_q.marked ? PH_MARK : PH_OPEN;
                    end
                end
                default: begin
                    if (out_ready) begin
                        ph_q <= PH_OPEN;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pbal_dec.sv
module pbal_dec
    import pbal_pkg::*;
#(
    parameter int T = 2,
    parameter int S = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit
);
    pbal_phase_e ph_q;
    grp_ctl_t    ctl_q;
    int          level;
    logic        step, push, pop;
    logic        head, last, g_nz, g_pos, at_lim;

    pbal_crd #(.T(T), .S(S)) u_crd (
        .clk(clk), .rst(rst), .step(step), .bit_in(in_bit), .level(level)
    );

    pbal_group #(.S(S)) u_grp (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .bit_in(in_bit),
        .head(head), .last(last), .g_nz(g_nz), .g_pos(g_pos)
    );

    assign at_lim = past_limit(level, T);

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_bit   = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        step      = 1'b0;
        case (ph_q)
            PH_OPEN: begin
                if (!at_lim) begin
                    in_ready  = out_ready;
                    out_valid = in_valid;
                    out_bit   = in_bit;
                    step      = in_valid && out_ready;
                end else begin
                    in_ready = 1'b1;
                    push     = in_valid;
                    step     = in_valid;
                end
            end
            PH_FILL: begin
                in_ready = 1'b1;
                push     = in_valid;
                step     = in_valid;
            end
            PH_MARK: begin
                in_ready = 1'b1;
                step     = in_valid;
            end
            default: begin
                out_valid = 1'b1;
                out_bit   = head ^ ctl_q.invert;
                pop       = out_ready;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_OPEN;
            ctl_q <= '0;
        end else begin
            case (ph_q)
                PH_OPEN, PH_FILL: begin
                    if (push) begin
                        if (!last) begin
                            ph_q <= PH_FILL;
                        end else if (g_nz) begin
                            ph_q         <= PH_MARK;
                            ctl_q.marked <= 1'b1;
                        end else begin
                            ph_q         <= PH_SEND;
                            ctl_q.invert <= 1'b0;
                            ctl_q.marked <= 1'b0;
                        end
                    end
                end
                PH_MARK: begin
                    if (in_valid) begin
                        ctl_q.invert <= in_bit;
                        ph_q         <= PH_SEND;
                    end
                end
                default: begin
                    if (out_ready && last) begin
                        ph_q <= PH_OPEN;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pbal_codec.sv
module pbal_codec #(
    parameter int T = 2,
    parameter int S = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic src_valid,
    output logic src_ready,
    input  logic src_bit,
    output logic line_tx_valid,
    input  logic line_tx_ready,
    output logic line_tx_bit,
    input  logic line_rx_valid,
    output logic line_rx_ready,
    input  logic line_rx_bit,
    output logic snk_valid,
    input  logic snk_ready,
    output logic snk_bit
);
    pbal_enc #(.T(T), .S(S)) u_enc (
        .clk(clk), .rst(rst),
        .in_valid(src_valid), .in_ready(src_ready), .in_bit(src_bit),
        .out_valid(line_tx_valid), .out_ready(line_tx_ready), .out_bit(line_tx_bit)
    );

    pbal_dec #(.T(T), .S(S)) u_dec (
        .clk(clk), .rst(rst),
        .in_valid(line_rx_valid), .in_ready(line_rx_ready), .in_bit(line_rx_bit),
        .out_valid(snk_valid), .out_ready(snk_ready), .out_bit(snk_bit)
    );
endmodule

// File: rtl/pbal_checker.sv
module pbal_checker #(
    parameter int T = 2,
    parameter int S = 2
) (
    input logic clk,
    input logic rst,
    input logic src_valid,
    input logic src_ready,
    input logic src_bit,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_bit,
    input logic rx_valid,
    input logic rx_ready,
    input logic rx_bit,
    input logic snk_valid,
    input logic snk_bit
);
    localparam int BOUND = T + S / 2;
    localparam int RUNMAX = 2 * BOUND;

    int   lcrd_q;
    int   run_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lcrd_q <= 0;
            run_q  <= 0;
            last_q <= 1'b0;
        end else if (tx_valid && tx_ready) begin
            lcrd_q <= tx_bit ? lcrd_q + 1 : lcrd_q - 1;
            run_q  <= (run_q != 0 && tx_bit == last_q) ? run_q + 1 : 1;
            last_q <= tx_bit;
        end
    end

    // R1: line balance held inside the window
    assert_crd_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (lcrd_q <= BOUND) && (lcrd_q >= -BOUND));

    // R2: identical-bit runs on the line are bounded
    assert_run_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUNMAX);

    // R3: an accepted bit that reaches the line at once is unchanged
    assert_pass_same_R3: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready && tx_valid) |-> (tx_bit == src_bit));

    // R7: line busy with no payload offered means a group or marker, so ready is low
    assert_ready_held_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !src_valid) |-> !src_ready);

    // R6: a decoder bit taken and delivered in one cycle is unchanged
    assert_rx_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (snk_valid && rx_valid && rx_ready) |-> (snk_bit == rx_bit));
endmodule

bind pbal_codec pbal_checker #(.T(T), .S(S)) u_chk (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_ready(src_ready), .src_bit(src_bit),
    .tx_valid(line_tx_valid), .tx_ready(line_tx_ready), .tx_bit(line_tx_bit),
    .rx_valid(line_rx_valid), .rx_ready(line_rx_ready), .rx_bit(line_rx_bit),
    .snk_valid(snk_valid), .snk_bit(snk_bit)
);

// File: tb/sim_pbal_codec.sv
module sim_pbal_codec;
    localparam int CLK_PERIOD = 10;
    localparam int T = 2;
    localparam int S = 2;
    localparam int BOUND = T + S / 2;
    localparam int K_PASS = 0;
    localparam int K_ZERO = 1;
    localparam int K_KEEP = 2;
    localparam int K_FLIP = 3;
    localparam int K_MARK = 4;
    localparam int WD_LIMIT = 90000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic src_valid = 1'b0, src_bit = 1'b0, src_ready;
    logic line_tx_valid, line_tx_ready, line_tx_bit;
    logic line_rx_valid, line_rx_ready, line_rx_bit;
    logic snk_valid, snk_bit;
    logic snk_ready = 1'b1;
    logic lgate = 1'b1;

    int checks = 0;
    int fails = 0;
    int kind_seen[5];

    bit in_q[$];
    bit exp_b[$];
    int exp_k[$];
    int used;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign line_rx_valid = line_tx_valid & lgate;
    assign line_rx_bit   = line_tx_bit;
    assign line_tx_ready = line_rx_ready & lgate;

    pbal_codec #(.T(T), .S(S)) u0 (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_ready(src_ready), .src_bit(src_bit),
        .line_tx_valid(line_tx_valid), .line_tx_ready(line_tx_ready), .line_tx_bit(line_tx_bit),
        .line_rx_valid(line_rx_valid), .line_rx_ready(line_rx_ready), .line_rx_bit(line_rx_bit),
        .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_bit(snk_bit)
    );

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, expv, $time);
        end
    endtask

    task automatic build_model();
        int c = 0;
        int i = 0;
        int n = in_q.size();
        exp_b.delete();
        exp_k.delete();
        while (i < n) begin
            if (c < T && c > -T) begin
                exp_b.push_back(in_q[i]);
                exp_k.push_back(K_PASS);
                c += in_q[i] ? 1 : -1;
                i++;
            end else begin
                int g = 0;
                bit inv;
                if (i + S > n) break;
                for (int j = 0; j < S; j++) g += in_q[i + j] ? 1 : -1;
                inv = (g != 0) && ((g > 0) == (c > 0));
                for (int j = 0; j < S; j++) begin
                    bit b = in_q[i + j] ^ inv;
                    exp_b.push_back(b);
                    exp_k.push_back(g == 0 ? K_ZERO : (inv ? K_FLIP : K_KEEP));
                    c += b ? 1 : -1;
                end
                if (g != 0) begin
                    exp_b.push_back(inv);
                    exp_k.push_back(K_MARK);
                    c += inv ? 1 : -1;
                end
                i += S;
            end
        end
        used = i;
    endtask

    task automatic run_phase(int nb, bit stall);
        int si = 0, k = 0, d = 0, cyc = 0;
        int lc = 0, run = 0;
        bit lastb = 1'b0;
        logic [15:0] lf = 16'hACE1;
        bit adv;
        in_q.delete();
        for (int p = 0; p < (1 << nb); p++)
            for (int b = 0; b < nb; b++) in_q.push_back(p[b]);
        for (int j = 0; j < 2 * S; j++) in_q.push_back(1'b0);
        build_model();

        @(negedge clk);
        rst = 1'b1; src_valid = 1'b0; lgate = 1'b1; snk_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #(CLK_PERIOD / 4);
        check(line_tx_valid == 1'b0, "R8 line_tx_valid after reset", line_tx_valid, 0);
        check(snk_valid == 1'b0, "R8 snk_valid after reset", snk_valid, 0);
        check(src_ready == 1'b1, "R8 src_ready after reset", src_ready, 1);

        while (!(k == exp_b.size() && d == used)) begin
            @(negedge clk);
            cyc++;
            if (cyc > WD_LIMIT) begin
                check(1'b0, "R6 watchdog expired", d, used);
                break;
            end
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lgate     = stall ? (lf[2:1] != 2'b00) : 1'b1;
            snk_ready = stall ? (lf[5:4] != 2'b00) : 1'b1;
            src_valid = (stall ? lf[8] | lf[9] : 1'b1) && (si < in_q.size());
            src_bit   = (si < in_q.size()) ? in_q[si] : 1'b0;
            #(CLK_PERIOD / 4);
            adv = src_valid && src_ready;
            if (adv && !line_tx_valid && k < exp_b.size())
                check(exp_k[k] != K_PASS, "R9 group gathered with line idle", exp_k[k], K_ZERO);
            if (line_tx_valid && line_tx_ready) begin
                if (k >= exp_b.size()) begin
                    check(1'b0, "R6 extra line bit", k, exp_b.size());
                end else begin
                    kind_seen[exp_k[k]]++;
                    if (exp_k[k] == K_PASS)
                        check(line_tx_bit == exp_b[k], "R3 passthrough bit", line_tx_bit, exp_b[k]);
                    else if (exp_k[k] == K_ZERO)
                        check(line_tx_bit == exp_b[k], "R4 balanced group bit", line_tx_bit, exp_b[k]);
                    else
                        check(line_tx_bit == exp_b[k], "R5 kept/inverted/marker bit", line_tx_bit, exp_b[k]);
                    if (exp_k[k] != K_PASS)
                        check(src_ready == 1'b0, "R7 ready during group or marker", src_ready, 0);
                end
                lc += line_tx_bit ? 1 : -1;
                run = (run != 0 && line_tx_bit == lastb) ? run + 1 : 1;
                lastb = line_tx_bit;
                check(lc <= BOUND && lc >= -BOUND, "R1 line balance", lc, BOUND);
                check(run <= 2 * BOUND, "R2 run length", run, 2 * BOUND);
                k++;
            end
            if (snk_valid && snk_ready) begin
                if (d >= in_q.size())
                    check(1'b0, "R6 extra decoded bit", d, in_q.size());
                else
                    check(snk_bit == in_q[d], "R6 decoded bit", snk_bit, in_q[d]);
                d++;
            end
            @(posedge clk);
            if (adv) si++;
        end
        check(d == used, "R6 decoded count", d, used);
        @(negedge clk);
        src_valid = 1'b0; lgate = 1'b1;
        repeat (4) begin
            @(negedge clk);
            #(CLK_PERIOD / 4);
            check(line_tx_valid == 1'b0, "R6 no trailing line bits", line_tx_valid, 0);
        end
    endtask

    initial begin
        for (int j = 0; j < 5; j++) kind_seen[j] = 0;
        run_phase(10, 1'b0);
        run_phase(8, 1'b1);
        check(kind_seen[K_ZERO] > 0, "R4 balanced groups occurred", kind_seen[K_ZERO], 1);
        check(kind_seen[K_KEEP] > 0, "R5 kept groups occurred", kind_seen[K_KEEP], 1);
        check(kind_seen[K_FLIP] > 0, "R5 inverted groups occurred", kind_seen[K_FLIP], 1);
        check(kind_seen[K_MARK] > 0, "R5 markers occurred", kind_seen[K_MARK], 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule